// File: doc/BRIEF.md
# Dual-Port Word Memory with Contention Arbitration

This block is a synchronous dual-port word memory with two independent ports, left and right. Each port has an enable, a write select, an output enable, an address, a write-data bus, a read-data bus with a valid flag, and a flag that marks the read data as unreliable. Each request is captured on a rising clock edge. The access takes effect on the next edge. Read data appears after that second edge. The memory has 2^ADDR_W words of DATA_W bits. The full-size configuration is ADDR_W = 14 and DATA_W = 9, which gives 16K words of 9 bits. The default build is a smaller 1K-word array.

Both ports may hit the same word in the same cycle. If both are reading, the block does nothing special. If at least one of them writes, an arbiter picks one winner and raises a busy flag to the other port. The busy port loses its write, and if it was reading, its data is marked unreliable. A role select decides where busy comes from:
- As master, the block drives its own arbitration result on the busy outputs.
- As slave, the block ignores its own arbiter and obeys busy inputs instead.

Several slices can therefore share one arbitration decision when they are cascaded to build a wider word. Separate data-in and data-out buses with a valid flag replace bidirectional pins.

Top module: `dpram_arb`

## Requirements
- R1: While reset is high, and after it is released, every output is 0 until a request produces a result.
- R2: A port with enable low writes nothing. Two edges after that request, its valid flag is 0 and its read data is 0.
- R3: Enable 1 with write 1 stores the write data at the address. Enable 1, write 0 and output enable 1 is a read. Two edges after the request edge, the read returns the stored word with valid set to 1. A read returns the word as it was before any write in the same cycle.
- R4: A read with output enable 0 gives valid 0 and data 0, and leaves the memory unchanged.
- R5: Both ports may read the same address in the same cycle. No busy flag is raised, and both ports return the stored word.
- R6: In master mode (role select 1), a clash is both ports enabled on the same address with at least one writing. After a clash, busy rises to exactly one port for the cycle following the request edge. The winner is decided as follows:
  - If a port's previous request was enabled on that same address and the other port's was not, that port requested first and wins.
  - Otherwise the left port wins.
- R7: The write of a busy port is not performed. The winner's write is performed.
- R8: A read by a busy port returns data with the unreliable flag set to 1. The unreliable flag is never 1 without valid.
- R9: Busy falls in the cycle after the first request edge that carries no clash.
- R10: In slave mode (role select 0), both busy outputs stay 0 and the internal arbiter has no effect. A busy input that is high at the execution edge of a port's request blocks that port's write and flags its read as unreliable.
- R11: Writes on different addresses from both ports in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms | input | 1 | Role select: 1 master (drives busy), 0 slave (takes busy) |
| lt_en | input | 1 | Left enable |
| lt_wr | input | 1 | Left write select (1 write, 0 read) |
| lt_oe | input | 1 | Left output enable |
| lt_addr | input | ADDR_W | Left address |
| lt_din | input | DATA_W | Left write data |
| lt_dout | output | DATA_W | Left read data, 0 when not valid |
| lt_dval | output | 1 | Left read data valid |
| lt_dbad | output | 1 | Left read data unreliable (port was busy) |
| lt_busy_o | output | 1 | Left busy driven by this block in master mode |
| lt_busy_i | input | 1 | Left busy taken from outside in slave mode |
| rt_en | input | 1 | Right enable |
| rt_wr | input | 1 | Right write select |
| rt_oe | input | 1 | Right output enable |
| rt_addr | input | ADDR_W | Right address |
| rt_din | input | DATA_W | Right write data |
| rt_dout | output | DATA_W | Right read data |
| rt_dval | output | 1 | Right read data valid |
| rt_dbad | output | 1 | Right read data unreliable |
| rt_busy_o | output | 1 | Right busy output (master mode) |
| rt_busy_i | input | 1 | Right busy input (slave mode) |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 9. With only 16 words, every address can be written before it is read. The random master phase confines traffic to four addresses, so clashes, first-requester wins and exact ties all occur often. The full 9-bit width is kept so that the read data shows whether a write from the winner or from the loser was stored. The slave phase drives the busy inputs at random while the two ports stay on disjoint halves of the array. This separates the effect of the busy inputs from any data collision.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  localparam int NPORT = 2;

  // Winner of a clash: a port that already held the address wins,
  // an exact tie goes to the left side.
  function automatic side_e pick_winner(input logic left_held,
                                        input logic right_held);
    if (right_held && !left_held) return SIDE_RIGHT;
    return SIDE_LEFT;
  endfunction

endpackage

// File: rtl/dpa_port_stage.sv
module dpa_port_stage #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i_en,
  input  logic              i_wr,
  input  logic              i_oe,
  input  logic [ADDR_W-1:0] i_addr,
  input  logic [DATA_W-1:0] i_din,
  output logic              s_en,
  output logic              s_wr,
  output logic              s_oe,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_din,
  output logic              h_en,
  output logic [ADDR_W-1:0] h_addr
);

  // Request register: the request captured at this edge executes at the next.
  always_ff @(posedge clk) begin
    if (rst) begin
      s_en <= 1'b0;
      s_wr <= 1'b0;
      s_oe <= 1'b0;
    end else begin
      s_en <= i_en;
      s_wr <= i_wr;
      s_oe <= i_oe;
    end
  end

  always_ff @(posedge clk) begin
    s_addr <= i_addr;
    s_din  <= i_din;
  end

  // History register: the request that executed one cycle earlier.
  always_ff @(posedge clk) begin
    if (rst) begin
      h_en   <= 1'b0;
      h_addr <= '0;
    end else begin
      h_en   <= s_en;
      h_addr <= s_addr;
    end
  end

endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              ms,
  input  logic [NPORT-1:0]  en,
  input  logic [NPORT-1:0]  wr,
  input  logic [ADDR_W-1:0] addr   [NPORT],
  input  logic [NPORT-1:0]  h_en,
  input  logic [ADDR_W-1:0] h_addr [NPORT],
  input  logic [NPORT-1:0]  busy_i,
  output logic [NPORT-1:0]  busy_o,
  output logic [NPORT-1:0]  block
);

  logic             clash;
  logic [NPORT-1:0] held;
  logic [NPORT-1:0] lose;
  side_e            win;

  assign clash = en[0] && en[1] && (addr[0] == addr[1]) && (wr[0] || wr[1]);

  for (genvar p = 0; p < NPORT; p++) begin : g_held
    assign held[p] = h_en[p] && (h_addr[p] == addr[p]);
  end

  assign win = pick_winner(held[0], held[1]);

  always_comb begin
    lose = '0;
    if (clash) begin
      if (win == SIDE_RIGHT) lose[0] = 1'b1;
      else                   lose[1] = 1'b1;
    end
  end

  assign busy_o = ms ? lose : '0;
  assign block  = ms ? lose : busy_i;

endmodule

// File: rtl/dpa_mem_core.sv
module dpa_mem_core
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORT-1:0]  we,
  input  logic [NPORT-1:0]  re,
  input  logic [NPORT-1:0]  flag,
  input  logic [ADDR_W-1:0] addr  [NPORT],
  input  logic [DATA_W-1:0] din   [NPORT],
  output logic [DATA_W-1:0] dout  [NPORT],
  output logic [NPORT-1:0]  dval,
  output logic [NPORT-1:0]  dbad
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Two write ports; the arbiter never lets both write one word.
  always_ff @(posedge clk) begin
    if (we[0]) mem[addr[0]] <= din[0];
    if (we[1]) mem[addr[1]] <= din[1];
  end

  // Read-before-write registered outputs, one set per port.
  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) begin
        dout[p] <= '0;
        dval[p] <= 1'b0;
        dbad[p] <= 1'b0;
      end else begin
        dout[p] <= re[p] ? mem[addr[p]] : '0;
        dval[p] <= re[p];
        dbad[p] <= re[p] && flag[p];
      end
    end
  end

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms,
  input  logic              lt_en,
  input  logic              lt_wr,
  input  logic              lt_oe,
  input  logic [ADDR_W-1:0] lt_addr,
  input  logic [DATA_W-1:0] lt_din,
  output logic [DATA_W-1:0] lt_dout,
  output logic              lt_dval,
  output logic              lt_dbad,
  output logic              lt_busy_o,
  input  logic              lt_busy_i,
  input  logic              rt_en,
  input  logic              rt_wr,
  input  logic              rt_oe,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic [DATA_W-1:0] rt_din,
  output logic [DATA_W-1:0] rt_dout,
  output logic              rt_dval,
  output logic              rt_dbad,
  output logic              rt_busy_o,
  input  logic              rt_busy_i
);

  logic [NPORT-1:0]  i_en, i_wr, i_oe;
  logic [ADDR_W-1:0] i_addr [NPORT];
  logic [DATA_W-1:0] i_din  [NPORT];

  logic [NPORT-1:0]  s_en, s_wr, s_oe, h_en;
  logic [ADDR_W-1:0] s_addr [NPORT];
  logic [ADDR_W-1:0] h_addr [NPORT];
  logic [DATA_W-1:0] s_din  [NPORT];

  logic [NPORT-1:0]  busy_o, block, we, re;
  logic [DATA_W-1:0] dout [NPORT];
  logic [NPORT-1:0]  dval, dbad;

  assign i_en = {rt_en, lt_en};
  assign i_wr = {rt_wr, lt_wr};
  assign i_oe = {rt_oe, lt_oe};
  assign i_addr[0] = lt_addr;
  assign i_addr[1] = rt_addr;
  assign i_din[0]  = lt_din;
  assign i_din[1]  = rt_din;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpa_port_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .i_en   (i_en[p]),
      .i_wr   (i_wr[p]),
      .i_oe   (i_oe[p]),
      .i_addr (i_addr[p]),
      .i_din  (i_din[p]),
      .s_en   (s_en[p]),
      .s_wr   (s_wr[p]),
      .s_oe   (s_oe[p]),
      .s_addr (s_addr[p]),
      .s_din  (s_din[p]),
      .h_en   (h_en[p]),
      .h_addr (h_addr[p])
    );
    assign we[p] = s_en[p] && s_wr[p] && !block[p];
    assign re[p] = s_en[p] && !s_wr[p] && s_oe[p];
  end

  dpa_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .ms     (ms),
    .en     (s_en),
    .wr     (s_wr),
    .addr   (s_addr),
    .h_en   (h_en),
    .h_addr (h_addr),
    .busy_i ({rt_busy_i, lt_busy_i}),
    .busy_o (busy_o),
    .block  (block)
  );

  dpa_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk  (clk),
    .rst  (rst),
    .we   (we),
    .re   (re),
    .flag (block),
    .addr (s_addr),
    .din  (s_din),
    .dout (dout),
    .dval (dval),
    .dbad (dbad)
  );

  assign lt_busy_o = busy_o[0];
  assign rt_busy_o = busy_o[1];
  assign lt_dout   = dout[0];
  assign rt_dout   = dout[1];
  assign lt_dval   = dval[0];
  assign rt_dval   = dval[1];
  assign lt_dbad   = dbad[0];
  assign rt_dbad   = dbad[1];

endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              ms,
  input logic              lt_en,
  input logic              lt_wr,
  input logic              lt_oe,
  input logic [ADDR_W-1:0] lt_addr,
  input logic [DATA_W-1:0] lt_din,
  input logic [DATA_W-1:0] lt_dout,
  input logic              lt_dval,
  input logic              lt_dbad,
  input logic              lt_busy_o,
  input logic              lt_busy_i,
  input logic              rt_en,
  input logic              rt_wr,
  input logic              rt_oe,
  input logic [ADDR_W-1:0] rt_addr,
  input logic [DATA_W-1:0] rt_din,
  input logic [DATA_W-1:0] rt_dout,
  input logic              rt_dval,
  input logic              rt_dbad,
  input logic              rt_busy_o,
  input logic              rt_busy_i
);

  logic clash_in;
  assign clash_in = lt_en && rt_en && (lt_addr == rt_addr) && (lt_wr || rt_wr);

  p_busy_one_side_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lt_busy_o, rt_busy_o}));

  p_clash_busies_r6: assert property (@(posedge clk) disable iff (rst)
    (ms && clash_in) |=> (!ms || (lt_busy_o || rt_busy_o)));

  p_busy_clears_r9: assert property (@(posedge clk) disable iff (rst)
    !clash_in |=> (!lt_busy_o && !rt_busy_o));

  p_slave_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !ms |-> (!lt_busy_o && !rt_busy_o));

  p_bad_has_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (lt_dbad |-> lt_dval) and (rt_dbad |-> rt_dval));

  p_read_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (lt_en && !lt_wr && lt_oe) |=> ##1 lt_dval);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !rt_en |=> ##1 (!rt_dval && rt_dout == '0));

  p_no_oe_r4: assert property (@(posedge clk) disable iff (rst)
    (lt_en && !lt_oe) |=> ##1 !lt_dval);

endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_dpram_arb.sv
`timescale 1ns/1ps
module sim_dpram_arb;

  localparam int AW = 4;
  localparam int DW = 9;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms  = 1'b1;
  logic lt_en = 0, lt_wr = 0, lt_oe = 0, lt_busy_i = 0;
  logic rt_en = 0, rt_wr = 0, rt_oe = 0, rt_busy_i = 0;
  logic [AW-1:0] lt_addr = '0, rt_addr = '0;
  logic [DW-1:0] lt_din = '0, rt_din = '0;
  logic [DW-1:0] lt_dout, rt_dout;
  logic lt_dval, lt_dbad, lt_busy_o, rt_dval, rt_dbad, rt_busy_o;

  always #10 clk = ~clk;

  dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 5) % 512);
  endfunction

  // ---------------- behavioural reference ----------------
  logic [DW-1:0] m_mem [NW];
  bit   q_en [2], q_wr [2], q_oe [2];
  int   q_a  [2];
  int   q_d  [2];
  bit   pv_en [2];
  int   pv_a  [2];
  int   e_dout [2];
  bit   e_dval [2], e_dbad [2];

  function automatic int loser();
    bit c, lh, rh;
    c  = q_en[0] && q_en[1] && q_a[0] == q_a[1] && (q_wr[0] || q_wr[1]);
    lh = pv_en[0] && pv_a[0] == q_a[0];
    rh = pv_en[1] && pv_a[1] == q_a[1];
    if (!c) return -1;
    if (rh && !lh) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < 2; p++) begin
        q_en[p] = 0; pv_en[p] = 0; pv_a[p] = 0;
        e_dout[p] = 0; e_dval[p] = 0; e_dbad[p] = 0;
      end
    end else begin
      int lo;
      bit blk [2];
      int rd [2];
      lo = loser();
      blk[0] = ms ? (lo == 0) : lt_busy_i;
      blk[1] = ms ? (lo == 1) : rt_busy_i;
      for (int p = 0; p < 2; p++) rd[p] = int'(m_mem[q_a[p]]);
      for (int p = 0; p < 2; p++)
        if (q_en[p] && q_wr[p] && !blk[p]) m_mem[q_a[p]] = DW'(q_d[p]);
      for (int p = 0; p < 2; p++) begin
        e_dval[p] = q_en[p] && !q_wr[p] && q_oe[p];
        e_dout[p] = e_dval[p] ? rd[p] : 0;
        e_dbad[p] = e_dval[p] && blk[p];
        pv_en[p] = q_en[p];
        pv_a[p]  = q_a[p];
      end
    end
    if (!rst) begin
      q_en[0] = lt_en; q_wr[0] = lt_wr; q_oe[0] = lt_oe; q_a[0] = int'(lt_addr); q_d[0] = int'(lt_din);
      q_en[1] = rt_en; q_wr[1] = rt_wr; q_oe[1] = rt_oe; q_a[1] = int'(rt_addr); q_d[1] = int'(rt_din);
    end
    cmp_on = 1;
  end

  // Per-cycle comparison against the reference (away from the rising edge).
  always @(negedge clk) begin
    if (cmp_on) begin
      int lo;
      string bt;
      lo = loser();
      bt = rst ? "R1" : (ms ? "R6" : "R10");
      chk(rst ? "R1" : "R3", "lt_dout", int'(lt_dout), e_dout[0]);
      chk(rst ? "R1" : "R3", "lt_dval", int'(lt_dval), int'(e_dval[0]));
      chk(rst ? "R1" : "R8", "lt_dbad", int'(lt_dbad), int'(e_dbad[0]));
      chk(rst ? "R1" : "R3", "rt_dout", int'(rt_dout), e_dout[1]);
      chk(rst ? "R1" : "R3", "rt_dval", int'(rt_dval), int'(e_dval[1]));
      chk(rst ? "R1" : "R8", "rt_dbad", int'(rt_dbad), int'(e_dbad[1]));
      chk(bt, "lt_busy_o", int'(lt_busy_o), int'(!rst && ms && lo == 0));
      chk(bt, "rt_busy_o", int'(rt_busy_o), int'(!rst && ms && lo == 1));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit le, input bit lw, input bit lo, input int la, input int ld,
                      input bit re, input bit rw, input bit ro, input int ra, input int rd,
                      input bit lb, input bit rb);
    @(negedge clk); #2;
    lt_en = le; lt_wr = lw; lt_oe = lo; lt_addr = AW'(la); lt_din = DW'(ld);
    rt_en = re; rt_wr = rw; rt_oe = ro; rt_addr = AW'(ra); rt_din = DW'(rd);
    lt_busy_i = lb; rt_busy_i = rb;
  endtask

  task automatic idle();
    step(0,0,0,0,0, 0,0,0,0,0, 0,0);
  endtask

  // read one address on one side and check it two edges later
  task automatic readback(input int side, input int a, input int exp, input string tag);
    if (side == 0) step(1,0,1,a,0, 0,0,0,0,0, 0,0);
    else           step(0,0,0,0,0, 1,0,1,a,0, 0,0);
    idle();
    @(negedge clk); #1;
    if (side == 0) chk(tag, "readback lt_dout", int'(lt_dout), exp);
    else           chk(tag, "readback rt_dout", int'(rt_dout), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset lt_dval", int'(lt_dval), 0);
    chk("R1", "reset rt_busy_o", int'(rt_busy_o), 0);
    @(negedge clk); #2 rst = 0;
    @(negedge clk); #1;
    chk("R1", "post-reset lt_dout", int'(lt_dout), 0);

    // R11: both ports write different words in the same cycle
    for (int i = 0; i < NW / 2; i++)
      step(1,1,0,i,pat(i), 1,1,0,i + NW/2,pat(i + NW/2), 0,0);
    idle();
    readback(0, 2, int'(pat(2)), "R11");
    readback(1, 10, int'(pat(10)), "R11");
    readback(1, 3, int'(pat(3)), "R3");

    // R2: disabled write request leaves the word alone
    step(0,1,1,5,9'h000, 0,0,0,0,0, 0,0);
    idle();
    @(negedge clk); #1;
    chk("R2", "disabled lt_dval", int'(lt_dval), 0);
    readback(0, 5, int'(pat(5)), "R2");

    // R4: read with output enable low
    step(1,0,0,6,0, 0,0,0,0,0, 0,0);
    idle();
    @(negedge clk); #1;
    chk("R4", "oe low lt_dval", int'(lt_dval), 0);
    chk("R4", "oe low lt_dout", int'(lt_dout), 0);
    readback(1, 6, int'(pat(6)), "R4");

    // R5: both ports read one word together
    step(1,0,1,7,0, 1,0,1,7,0, 0,0);
    idle(); #1;
    chk("R5", "shared read lt_busy_o", int'(lt_busy_o), 0);
    chk("R5", "shared read rt_busy_o", int'(rt_busy_o), 0);
    @(negedge clk); #1;
    chk("R5", "shared read lt_dout", int'(lt_dout), int'(pat(7)));
    chk("R5", "shared read rt_dout", int'(rt_dout), int'(pat(7)));

    // R6/R7: exact tie, both write word 1 -> left wins
    step(1,1,0,1,9'h0AA, 1,1,0,1,9'h155, 0,0);
    idle(); #1;
    chk("R6", "tie rt_busy_o", int'(rt_busy_o), 1);
    chk("R6", "tie lt_busy_o", int'(lt_busy_o), 0);
    readback(0, 1, 9'h0AA, "R7");

    // R6/R7: right held word 4 first, left then writes it -> right wins
    step(0,0,0,0,0, 1,0,1,4,0, 0,0);
    step(1,1,0,4,9'h033, 1,0,1,4,0, 0,0);
    idle(); #1;
    chk("R6", "first-comer lt_busy_o", int'(lt_busy_o), 1);
    chk("R6", "first-comer rt_busy_o", int'(rt_busy_o), 0);
    @(negedge clk); #1;
    chk("R8", "winner rt_dbad", int'(rt_dbad), 0);
    readback(1, 4, int'(pat(4)), "R7");

    // R8: tie, left writes, right reads -> right busy, read flagged
    step(1,1,0,6,9'h1C3, 1,0,1,6,0, 0,0);
    idle(); #1;
    chk("R6", "rd/wr tie rt_busy_o", int'(rt_busy_o), 1);
    @(negedge clk); #1;
    chk("R8", "loser rt_dbad", int'(rt_dbad), 1);
    chk("R8", "loser rt_dval", int'(rt_dval), 1);
    readback(0, 6, 9'h1C3, "R7");

    // R9: two clash cycles, then busy must drop
    step(1,1,0,2,9'h011, 1,1,0,2,9'h022, 0,0);
    step(1,1,0,2,9'h012, 1,1,0,2,9'h023, 0,0);
    idle(); #1;
    chk("R9", "held clash rt_busy_o", int'(rt_busy_o), 1);
    idle(); #1;
    chk("R9", "clear rt_busy_o", int'(rt_busy_o), 0);
    chk("R9", "clear lt_busy_o", int'(lt_busy_o), 0);

    // R10: slave mode, busy inputs rule
    ms = 0;
    step(1,1,0,9,9'h0F0, 1,1,0,11,9'h00F, 0,0);
    step(0,0,0,0,0, 0,0,0,0,0, 1,0);
    idle(); #1;
    chk("R10", "slave lt_busy_o", int'(lt_busy_o), 0);
    readback(0, 9, int'(pat(9)), "R10");
    readback(1, 11, 9'h00F, "R10");
    step(1,1,0,12,9'h0C5, 1,0,1,12,0, 0,0);
    idle(); #1;
    chk("R10", "slave clash rt_busy_o", int'(rt_busy_o), 0);
    @(negedge clk); #1;
    chk("R10", "slave clash rt_dbad", int'(rt_dbad), 0);
    readback(1, 12, 9'h0C5, "R10");

    // random master traffic on four words
    ms = 1;
    idle();
    for (int n = 0; n < 400; n++)
      step($urandom % 4 != 0, $urandom % 2 == 1, $urandom % 4 != 0, int'($urandom % 4), int'($urandom % 512),
           $urandom % 4 != 0, $urandom % 2 == 1, $urandom % 4 != 0, int'($urandom % 4), int'($urandom % 512),
           0, 0);
    // random slave traffic on disjoint halves
    idle();
    ms = 0;
    for (int n = 0; n < 400; n++)
      step($urandom % 4 != 0, $urandom % 2 == 1, $urandom % 4 != 0, int'($urandom % 8), int'($urandom % 512),
           $urandom % 4 != 0, $urandom % 2 == 1, $urandom % 4 != 0, int'(8 + $urandom % 8), int'($urandom % 512),
           $urandom % 3 == 0, $urandom % 3 == 0);
    idle();
    idle();
    @(negedge clk); #1;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule